// File: doc/BRIEF.md
# DRAM ECC Error Log and Report Registers

This block sits beside the ECC checker of a two-channel DRAM controller and keeps a record of error events. It takes single-cycle strobes from five sources: correctable ECC errors, uncorrectable ECC errors, refresh timeouts, locked accesses that target non-DRAM space, and thermal sensor trips. Each strobe latches a sticky flag. Software clears a flag by writing 1 to it.

An ECC strobe also comes with the failing 33-bit address, the channel that failed and the 8-bit syndrome. The block keeps one copy of these details, and it decides which event owns that copy:
- A correctable error is recorded only when no ECC error is already held.
- An uncorrectable error is recorded unless an uncorrectable error is already held. It therefore replaces any correctable details.

A per-source enable register gates which pending flags raise the system-error output. All registers sit behind a small register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `ecc_err_log`

## Requirements
- R1: After synchronous reset, the flag, enable, address and syndrome registers all read 0 and `serr_o` is low.
- R2: A strobe sets its flag in the status register (select 0), one cycle after the strobe. The flag positions are: correctable at bit 0, uncorrectable at bit 1, refresh timeout at bit 8, lock to non-DRAM at bit 9, thermal at bit 11. Every other bit reads 0.
- R3: A write to select 0 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If a strobe and a clearing write hit the same flag in the same cycle, the flag is set afterwards.
- R5: A correctable strobe records its address, channel and syndrome only when neither ECC flag is set. Otherwise the recorded details stay as they were.
- R6: An uncorrectable strobe records its details unless the uncorrectable flag is already set. This holds even when correctable details are held. When both ECC strobes arrive in the same cycle, the uncorrectable details are kept.
- R7: The recorded details read back as follows:
  - Select 2 returns address bits 15:7 in bits 15:7, zeros in bits 6:1, and the channel in bit 0.
  - Select 3 returns address bits 31:16.
  - Select 4 returns address bit 32 in bit 0, with all other bits 0.
  - Select 5 returns the syndrome in bits 7:0.
- R8: The enable register (select 1) is read/write. Only bits 0, 1, 8, 9 and 11 are writable; the other bits read 0.
- R9: `serr_o` is high while any flag and its enable bit at the same position are both set.
- R10: Writes to selects 2 through 7 have no effect, and selects 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_evt | input | 1 | Correctable ECC error strobe |
| ue_evt | input | 1 | Uncorrectable ECC error strobe |
| rfto_evt | input | 1 | Refresh timeout strobe |
| lock_evt | input | 1 | Locked access to non-DRAM space strobe |
| therm_evt | input | 1 | Thermal sensor event strobe |
| ecc_addr | input | 33 | Failing address of the ECC strobe |
| ecc_chan | input | 1 | Failing channel of the ECC strobe |
| ecc_syn | input | 8 | Syndrome of the ECC strobe |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` (combinational) |
| serr_o | output | 1 | System-error request |

## Verification
Two kinds of internal fault would show at the ports:
- A wrong flag state shows at once on a status read, and on `serr_o` in the cycle after the strobe or write that caused it.
- A wrong capture decision is silent until the address or syndrome is read. The bench therefore reads the details back right after every contested capture: correctable over correctable, uncorrectable over correctable, uncorrectable over uncorrectable, and both strobes in the same cycle. A stale or overwritten record is caught one cycle after the offending strobe.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;

    parameter int REG_W     = 16;
    parameter int ADDR_W    = 33;
    parameter int SYN_W     = 8;
    parameter int SEL_W     = 3;
    parameter int GRAIN_LSB = 7;
    parameter int N_SRC     = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS   = 3'd0,
        SEL_CMD      = 3'd1,
        SEL_ADDR_LO  = 3'd2,
        SEL_ADDR_HI  = 3'd3,
        SEL_ADDR_EXT = 3'd4,
        SEL_SYN      = 3'd5
    } reg_sel_e;

    typedef enum int {
        SRC_CE    = 0,
        SRC_UE    = 1,
        SRC_RFTO  = 2,
        SRC_LOCK  = 3,
        SRC_THERM = 4
    } src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              chan;
        logic [SYN_W-1:0]  syn;
    } ecc_info_t;

    function automatic int src_bit(input int s);
        case (s)
            SRC_CE:    return 0;
            SRC_UE:    return 1;
            SRC_RFTO:  return 8;
            SRC_LOCK:  return 9;
            default:   return 11;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] src_to_flags(input logic [N_SRC-1:0] ev);
        logic [REG_W-1:0] f;
        f = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (ev[s]) f[src_bit(s)] = 1'b1;
        end
        return f;
    endfunction

    localparam logic [REG_W-1:0] FLAG_MASK = src_to_flags({N_SRC{1'b1}});

endpackage

// File: rtl/elog_status.sv
module elog_status
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] ev,
    input  logic             clr_we,
    input  logic [REG_W-1:0] clr_data,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;
    logic [REG_W-1:0] stat_d;

    always_comb begin
        set_v  = src_to_flags(ev);
        clr_v  = clr_we ? (clr_data & FLAG_MASK) : '0;
        // a new event wins over a same-cycle clear
        stat_d = (stat_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/elog_capture.sv
module elog_capture
    import ecc_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce_evt,
    input  logic      ue_evt,
    input  logic      ce_held,
    input  logic      ue_held,
    input  ecc_info_t info_in,
    output ecc_info_t info_q
);
    logic take_ue;
    logic take_ce;

    always_comb begin
        take_ue = ue_evt && !ue_held;
        take_ce = ce_evt && !ue_evt && !ce_held && !ue_held;
    end

    always_ff @(posedge clk) begin
        if (rst)                   info_q <= '0;
        else if (take_ue || take_ce) info_q <= info_in;
    end
endmodule

// File: rtl/elog_regs.sv
module elog_regs
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] stat_q,
    input  ecc_info_t        info_q,
    output logic [REG_W-1:0] cmd_q,
    output logic [REG_W-1:0] rdata
);
    localparam int HI_LSB  = REG_W;
    localparam int HI_MSB  = 2 * REG_W - 1;
    localparam int EXT_W   = ADDR_W - 2 * REG_W;
    localparam int LO_PAD  = GRAIN_LSB - 1;

    logic [REG_W-1:0] w_lo;
    logic [REG_W-1:0] w_hi;
    logic [REG_W-1:0] w_ext;
    logic [REG_W-1:0] w_syn;

    always_ff @(posedge clk) begin
        if (rst)
            cmd_q <= '0;
        else if (we && sel == SEL_CMD)
            cmd_q <= wdata & FLAG_MASK;
    end

    always_comb begin
        w_lo  = {info_q.addr[REG_W-1:GRAIN_LSB], {LO_PAD{1'b0}}, info_q.chan};
        w_hi  = info_q.addr[HI_MSB:HI_LSB];
        w_ext = {{(REG_W-EXT_W){1'b0}}, info_q.addr[ADDR_W-1:2*REG_W]};
        w_syn = {{(REG_W-SYN_W){1'b0}}, info_q.syn};
        case (sel)
            SEL_STATUS:   rdata = stat_q;
            SEL_CMD:      rdata = cmd_q;
            SEL_ADDR_LO:  rdata = w_lo;
            SEL_ADDR_HI:  rdata = w_hi;
            SEL_ADDR_EXT: rdata = w_ext;
            SEL_SYN:      rdata = w_syn;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_evt,
    input  logic              ue_evt,
    input  logic              rfto_evt,
    input  logic              lock_evt,
    input  logic              therm_evt,
    input  logic [ADDR_W-1:0] ecc_addr,
    input  logic              ecc_chan,
    input  logic [SYN_W-1:0]  ecc_syn,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              serr_o
);
    localparam int CE_BIT = src_bit(SRC_CE);
    localparam int UE_BIT = src_bit(SRC_UE);

    logic [N_SRC-1:0] ev;
    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] cmd_q;
    logic             clr_we;
    ecc_info_t        info_in;
    ecc_info_t        info_q;
    logic [SYN_W-1:0] log_syn;

    always_comb begin
        ev            = '0;
        ev[SRC_CE]    = ce_evt;
        ev[SRC_UE]    = ue_evt;
        ev[SRC_RFTO]  = rfto_evt;
        ev[SRC_LOCK]  = lock_evt;
        ev[SRC_THERM] = therm_evt;
        clr_we        = reg_we && (reg_sel == SEL_STATUS);
        info_in.addr  = ecc_addr;
        info_in.chan  = ecc_chan;
        info_in.syn   = ecc_syn;
        log_syn       = info_q.syn;
    end

    elog_status u_status (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .clr_we   (clr_we),
        .clr_data (reg_wdata),
        .stat_q   (stat_q)
    );

    elog_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .ce_evt  (ce_evt),
        .ue_evt  (ue_evt),
        .ce_held (stat_q[CE_BIT]),
        .ue_held (stat_q[UE_BIT]),
        .info_in (info_in),
        .info_q  (info_q)
    );

    elog_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .stat_q (stat_q),
        .info_q (info_q),
        .cmd_q  (cmd_q),
        .rdata  (reg_rdata)
    );

    assign serr_o = |(stat_q & cmd_q);
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
    import ecc_log_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ce_evt,
    input logic             ue_evt,
    input logic             reg_we,
    input logic [SEL_W-1:0] reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             serr_o,
    input logic [REG_W-1:0] stat_q,
    input logic [REG_W-1:0] cmd_q,
    input logic [SYN_W-1:0] log_syn
);
    logic wr_stat;
    logic wr_cmd;
    assign wr_stat = reg_we && (reg_sel == SEL_STATUS);
    assign wr_cmd  = reg_we && (reg_sel == SEL_CMD);

    // R2
    ue_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ue_evt |=> stat_q[1]);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[1] && !ue_evt) |=> !stat_q[1]);

    // R4
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[0] && ce_evt) |=> stat_q[0]);

    // R5
    ce_no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && !ue_evt) |=> $stable(log_syn));

    // R6
    ue_keeps_first_chk: assert property (@(posedge clk) disable iff (rst)
        stat_q[1] |=> $stable(log_syn));

    // R8
    cmd_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_CMD) |-> ((reg_rdata & ~FLAG_MASK) == '0));

    // R9
    serr_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (ue_evt && cmd_q[1] && !wr_cmd) |=> serr_o);
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_evt    (ce_evt),
    .ue_evt    (ue_evt),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .serr_o    (serr_o),
    .stat_q    (stat_q),
    .cmd_q     (cmd_q),
    .log_syn   (log_syn)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst;
    logic        ce_evt, ue_evt, rfto_evt, lock_evt, therm_evt;
    logic [32:0] ecc_addr;
    logic        ecc_chan;
    logic [7:0]  ecc_syn;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        serr_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ecc_err_log dut (
        .clk(clk), .rst(rst),
        .ce_evt(ce_evt), .ue_evt(ue_evt), .rfto_evt(rfto_evt),
        .lock_evt(lock_evt), .therm_evt(therm_evt),
        .ecc_addr(ecc_addr), .ecc_chan(ecc_chan), .ecc_syn(ecc_syn),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .serr_o(serr_o)
    );

    // evt order: {therm, lock, rfto, ue, ce}
    typedef struct packed {
        logic [4:0]  evt;
        logic        wr;
        logic [2:0]  wsel;
        logic [15:0] wdata;
        logic [32:0] addr;
        logic        chan;
        logic [7:0]  syn;
        logic [2:0]  rsel;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{5'b00001, 1'b0, 3'd0, 16'h0000, 33'h1_2345_6789, 1'b1, 8'hA5, 3'd0, 16'h0001},
        '{5'b00000, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd2, 16'h6781},
        '{5'b00000, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd3, 16'h2345},
        '{5'b00000, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd4, 16'h0001},
        '{5'b00000, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd5, 16'h00A5},
        '{5'b00001, 1'b0, 3'd0, 16'h0000, 33'h0_0000_1000, 1'b0, 8'h3C, 3'd5, 16'h00A5},
        '{5'b00010, 1'b0, 3'd0, 16'h0000, 33'h0_ABCD_EF80, 1'b0, 8'h77, 3'd5, 16'h0077},
        '{5'b00000, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd0, 16'h0003},
        '{5'b00010, 1'b0, 3'd0, 16'h0000, 33'h1_1111_1111, 1'b1, 8'h11, 3'd5, 16'h0077},
        '{5'b00000, 1'b1, 3'd0, 16'h0001, 33'h0,           1'b0, 8'h00, 3'd0, 16'h0002},
        '{5'b11100, 1'b0, 3'd0, 16'h0000, 33'h0,           1'b0, 8'h00, 3'd0, 16'h0B02},
        '{5'b00001, 1'b1, 3'd0, 16'hFFFF, 33'h0_0000_0F00, 1'b1, 8'hEE, 3'd0, 16'h0001},
        '{5'b00000, 1'b1, 3'd0, 16'h0001, 33'h0,           1'b0, 8'h00, 3'd0, 16'h0000},
        '{5'b00000, 1'b1, 3'd1, 16'hFFFF, 33'h0,           1'b0, 8'h00, 3'd1, 16'h0B03},
        '{5'b00000, 1'b1, 3'd5, 16'h00FF, 33'h0,           1'b0, 8'h00, 3'd5, 16'h0077},
        '{5'b00011, 1'b0, 3'd0, 16'h0000, 33'h1_0000_0080, 1'b1, 8'h5A, 3'd5, 16'h005A}
    };
    string VTAG [NV] = '{"R2","R7","R7","R7","R7","R5","R6","R2","R6","R3",
                         "R2","R4","R3","R8","R10","R6"};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {ce_evt, ue_evt, rfto_evt, lock_evt, therm_evt} = '0;
        reg_we = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        {therm_evt, lock_evt, rfto_evt, ue_evt, ce_evt} = v.evt;
        ecc_addr = v.addr; ecc_chan = v.chan; ecc_syn = v.syn;
        reg_we = v.wr; reg_sel = v.wsel; reg_wdata = v.wdata;
        @(posedge clk);
        #1;
        idle();
        reg_sel = v.rsel;
        #1;
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1;
        idle();
        #1;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [15:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        #(20 * 20000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] r;
        idle();
        ecc_addr = '0; ecc_chan = 1'b0; ecc_syn = '0; reg_sel = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1 reset state
        for (int s = 0; s < 6; s++) begin
            rd_reg(3'(s), r);
            check("R1 reg", r, 16'h0000);
        end
        check("R1 serr", {15'b0, serr_o}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i]);
            check(VTAG[i], reg_rdata, VEC[i].exp);
        end

        // R6 both strobes: uncorrectable address kept
        rd_reg(3'd2, r);
        check("R6 addr_lo", r, 16'h0081);
        rd_reg(3'd4, r);
        check("R6 addr_ext", r, 16'h0001);
        // R10 unused selects read 0
        rd_reg(3'd6, r);
        check("R10 sel6", r, 16'h0000);
        // R9 flags 0x0003 with enable 0x0B03
        check("R9 serr on", {15'b0, serr_o}, 16'h0001);
        wr_reg(3'd1, 16'h0000);
        check("R9 serr off by enable", {15'b0, serr_o}, 16'h0000);
        wr_reg(3'd1, 16'h0100);
        check("R9 serr unrelated flag", {15'b0, serr_o}, 16'h0000);
        @(negedge clk);
        rfto_evt = 1'b1;
        @(posedge clk);
        #1 idle();
        #1;
        check("R9 serr rfto", {15'b0, serr_o}, 16'h0001);
        wr_reg(3'd0, 16'h0100);
        check("R9 serr cleared", {15'b0, serr_o}, 16'h0000);
        rd_reg(3'd0, r);
        check("R3 rfto cleared", r, 16'h0003);

        // R5 after full clear a correctable error logs again
        wr_reg(3'd0, 16'hFFFF);
        step('{5'b00001, 1'b0, 3'd0, 16'h0, 33'h0_0000_4200, 1'b0, 8'h42, 3'd5, 16'h0});
        check("R5 relog", reg_rdata, 16'h0042);

        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        #1;
        for (int s = 0; s < 6; s++) begin
            rd_reg(3'(s), r);
            check("R1 rerst", r, 16'h0000);
        end
        check("R1 rerst serr", {15'b0, serr_o}, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule